// File: doc/BRIEF.md
# Two-Stage Round-Robin Switch Allocator

This block decides, every cycle, which virtual channels of a router may cross the switch. Each input port holds several virtual channels (VCs), and each VC may ask for an output port. The allocator returns a grant matrix with the same shape as the request matrix. A granted VC sends one flit through the crossbar in that cycle.

The allocator works in two arbitration stages. First, each input port picks one of its requesting VCs with a rotating-priority arbiter. Second, each output port picks one of the inputs whose chosen VC targets it, also with a rotating-priority arbiter. Grants follow combinationally from requests within the same cycle. The priority pointers move only on the clock edge, and only when a grant they produced was actually used. The result is always a legal match: one grant per input at most and one per output at most. It is not guaranteed to be maximal.

A request bit sits at flat index `(i*NUM_VC + v)*NUM_OUT + o` for input `i`, VC `v` and output `o`. The grant vector uses the same indexing.

Top module: `sa_alloc`

## Requirements
- R1: A grant bit is set only where the matching request bit is set.
- R2: At most one grant bit is set among all the VCs and outputs of one input port.
- R3: At most one grant bit is set among all the inputs and VCs that address one output port.
- R4: When a VC sets more than one output bit, only its lowest-numbered set output counts as its target; no grant is ever given on its other bits.
- R5: Each input port chooses among its requesting VCs in round-robin order. After reset VC 0 has top priority. After an input's chosen VC is granted, the VC after it (wrapping) has top priority at that input.
- R6: Each output port chooses among the inputs that selected it in round-robin order. After reset input 0 has top priority. After output o grants input i, input i+1 (wrapping) has top priority at output o.
- R7: An input whose chosen VC is not granted by its output keeps its VC priority unchanged for the next cycle.
- R8: An output port with no requesting input in a cycle keeps its input priority unchanged.
- R9: Grants depend combinationally on the current requests. A change of requests between clock edges changes the grants without waiting for an edge.
- R10: Whenever any request bit is set, at least one grant bit is set.
- R11: While reset (active-low `rst_n`) is low, all priority pointers return to their start positions, and with no requests the grant vector is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; priority pointers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the priority pointers |
| req_mat | input | NUM_IN*NUM_VC*NUM_OUT | Request matrix, bit (i*NUM_VC+v)*NUM_OUT+o |
| gnt_mat | output | NUM_IN*NUM_VC*NUM_OUT | Grant matrix, same indexing as req_mat |

## Verification
The assertions check the legality of the match on every cycle: grants only on requested bits, one grant per input and per output, no grant above a VC's lowest requested output, and at least one grant whenever anything is requested. Whether the round-robin order is correct cannot be seen in a single cycle. This covers the input pointer holding after a loss, an idle output holding its pointer, and the wrap after the last requester. The bench shows these by comparing every cycle against a behavioural model that keeps its own pointers. It also uses directed sequences whose grants are worked out by hand. The same-cycle response to a mid-cycle change of requests is also shown only by the bench.

// File: rtl/sa_alloc_pkg.sv
package sa_alloc_pkg;

  // Flat position of request (input i, vc v, output o).
  function automatic int req_bit(input int i, input int v, input int o,
                                 input int nvc, input int nout);
    return (i * nvc + v) * nout + o;
  endfunction

  // (a + b) modulo n for small non-negative operands.
  function automatic int wrap_add(input int a, input int b, input int n);
    int s;
    s = a + b;
    while (s >= n) s = s - n;
    return s;
  endfunction

  // Width of an index into n items, never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sa_tgt_sel.sv
module sa_tgt_sel #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] sel,
  output logic         hit
);
  // Lowest-numbered set bit wins; other bits are dropped.
  always_comb begin
    sel = '0;
    hit = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!hit && req[k]) begin
        sel[k] = 1'b1;
        hit    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sa_rr_arb.sv
module sa_rr_arb #(
  parameter int N = 2,
  localparam int IW = sa_alloc_pkg::idx_w(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  import sa_alloc_pkg::*;

  logic [IW-1:0] ptr_q;

  // Search starting at the pointer; first requester found wins.
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!any && req[wrap_add(int'(ptr_q), k, N)]) begin
        any                            = 1'b1;
        gnt[wrap_add(int'(ptr_q), k, N)] = 1'b1;
        gnt_idx                        = IW'(wrap_add(int'(ptr_q), k, N));
      end
    end
  end

  // Pointer moves past the winner only when the grant was used.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (adv && any)
      ptr_q <= IW'(wrap_add(int'(gnt_idx), 1, N));
  end
endmodule

// File: rtl/sa_alloc.sv
module sa_alloc #(
  parameter int NUM_IN  = 5,
  parameter int NUM_VC  = 2,
  parameter int NUM_OUT = 5,
  localparam int REQ_W  = NUM_IN * NUM_VC * NUM_OUT,
  localparam int VCW    = sa_alloc_pkg::idx_w(NUM_VC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REQ_W-1:0] req_mat,
  output logic [REQ_W-1:0] gnt_mat
);
  import sa_alloc_pkg::*;

  // Named internal events (visible to the bound checker).
  logic [NUM_OUT-1:0] vc_tgt   [NUM_IN][NUM_VC];
  logic [NUM_VC-1:0]  vc_any   [NUM_IN];
  logic [NUM_VC-1:0]  in_pick  [NUM_IN];
  logic [VCW-1:0]     in_pidx  [NUM_IN];
  logic               in_valid [NUM_IN];
  logic               in_won   [NUM_IN];
  logic [NUM_OUT-1:0] sel_tgt  [NUM_IN];
  logic [NUM_IN-1:0]  out_req  [NUM_OUT];
  logic [NUM_IN-1:0]  out_gnt  [NUM_OUT];

  // Per-VC target decode: lowest requested output.
  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      localparam int BASE = req_bit(i, v, 0, NUM_VC, NUM_OUT);
      sa_tgt_sel #(.N(NUM_OUT)) u_tgt (
        .req (req_mat[BASE +: NUM_OUT]),
        .sel (vc_tgt[i][v]),
        .hit (vc_any[i][v])
      );
    end

    // Stage one: choose a VC at this input.
    sa_rr_arb #(.N(NUM_VC)) u_in_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (vc_any[i]),
      .adv     (in_won[i]),
      .gnt     (in_pick[i]),
      .gnt_idx (in_pidx[i]),
      .any     (in_valid[i])
    );

    always_comb begin
      sel_tgt[i] = '0;
      for (int v = 0; v < NUM_VC; v++)
        if (in_valid[i] && (int'(in_pidx[i]) == v))
          sel_tgt[i] = vc_tgt[i][v];
    end

    always_comb begin
      in_won[i] = 1'b0;
      for (int o = 0; o < NUM_OUT; o++)
        in_won[i] = in_won[i] | out_gnt[o][i];
    end
  end

  // Stage two: each output chooses among inputs that selected it.
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic out_any;

    always_comb
      for (int i = 0; i < NUM_IN; i++)
        out_req[o][i] = sel_tgt[i][o];

    sa_rr_arb #(.N(NUM_IN)) u_out_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (out_req[o]),
      .adv     (1'b1),
      .gnt     (out_gnt[o]),
      .gnt_idx (),
      .any     (out_any)
    );
  end

  // Grant = VC chosen at its input AND input chosen at the output.
  for (genvar i = 0; i < NUM_IN; i++) begin : g_gi
    for (genvar v = 0; v < NUM_VC; v++) begin : g_gv
      for (genvar o = 0; o < NUM_OUT; o++) begin : g_go
        assign gnt_mat[req_bit(i, v, o, NUM_VC, NUM_OUT)] = in_pick[i][v] & out_gnt[o][i];
      end
    end
  end
endmodule

// File: rtl/sa_alloc_chk.sv
module sa_alloc_chk #(
  parameter int NUM_IN  = 5,
  parameter int NUM_VC  = 2,
  parameter int NUM_OUT = 5,
  localparam int REQ_W  = NUM_IN * NUM_VC * NUM_OUT,
  localparam int ROW    = NUM_VC * NUM_OUT,
  localparam int COL    = NUM_IN * NUM_VC
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REQ_W-1:0] req_mat,
  input logic [REQ_W-1:0] gnt_mat
);
  import sa_alloc_pkg::*;

  logic [COL-1:0] col_gnt [NUM_OUT];

  always_comb
    for (int o = 0; o < NUM_OUT; o++)
      for (int i = 0; i < NUM_IN; i++)
        for (int v = 0; v < NUM_VC; v++)
          col_gnt[o][i*NUM_VC+v] = gnt_mat[req_bit(i, v, o, NUM_VC, NUM_OUT)];

  assert_gnt_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_mat & ~req_mat) == '0);

  assert_some_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_mat) |-> (|gnt_mat));

  for (genvar i = 0; i < NUM_IN; i++) begin : g_row
    assert_one_per_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_mat[i*ROW +: ROW]));
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_col
    assert_one_per_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_gnt[o]));
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_li
    for (genvar v = 0; v < NUM_VC; v++) begin : g_lv
      for (genvar o = 1; o < NUM_OUT; o++) begin : g_lo
        localparam int BASE = req_bit(i, v, 0, NUM_VC, NUM_OUT);
        assert_lowest_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
          gnt_mat[BASE + o] |-> (req_mat[BASE +: o] == '0));
      end
    end
  end
endmodule

bind sa_alloc sa_alloc_chk #(
  .NUM_IN  (NUM_IN),
  .NUM_VC  (NUM_VC),
  .NUM_OUT (NUM_OUT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_mat (req_mat),
  .gnt_mat (gnt_mat)
);

// File: tb/tb_sa_alloc.sv
`timescale 1ns/1ps
module tb_sa_alloc;
  localparam int NI = 5;
  localparam int NV = 2;
  localparam int NO = 5;
  localparam int W  = NI * NV * NO;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] req_mat = '0;
  logic [W-1:0] gnt_mat;

  int n_chk = 0;
  int n_fail = 0;
  int in_ptr [NI];
  int out_ptr [NO];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sa_alloc #(.NUM_IN(NI), .NUM_VC(NV), .NUM_OUT(NO)) dut (
    .clk(clk), .rst_n(rst_n), .req_mat(req_mat), .gnt_mat(gnt_mat)
  );

  function automatic int bidx(int i, int v, int o);
    return (i * NV + v) * NO + o;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NI; i++) in_ptr[i] = 0;
    for (int o = 0; o < NO; o++) out_ptr[o] = 0;
  endtask

  // Behavioural reference: VC choice per input, then input choice per output.
  task automatic model(input logic [W-1:0] r, input bit commit, output logic [W-1:0] e);
    int pv [NI];
    int pt [NI];
    e = '0;
    for (int i = 0; i < NI; i++) begin
      pv[i] = -1; pt[i] = -1;
      for (int k = 0; k < NV; k++) begin
        int vv;
        vv = (in_ptr[i] + k) % NV;
        if (pv[i] < 0)
          for (int o = 0; o < NO; o++)
            if (pv[i] < 0 && r[bidx(i, vv, o)]) begin pv[i] = vv; pt[i] = o; end
      end
    end
    for (int o = 0; o < NO; o++) begin
      int win;
      win = -1;
      for (int k = 0; k < NI; k++) begin
        int ii;
        ii = (out_ptr[o] + k) % NI;
        if (win < 0 && pv[ii] >= 0 && pt[ii] == o) win = ii;
      end
      if (win >= 0) begin
        e[bidx(win, pv[win], o)] = 1'b1;
        if (commit) begin
          out_ptr[o]  = (win + 1) % NI;
          in_ptr[win] = (pv[win] + 1) % NV;
        end
      end
    end
  endtask

  // Drive at negedge, compare mid-cycle, advance model for next edge.
  task automatic apply(input logic [W-1:0] r, input string tag,
                       input bit dir, input logic [W-1:0] dexp);
    logic [W-1:0] e;
    @(negedge clk);
    req_mat = r;
    #2;
    model(r, 1'b1, e);
    check({"R5 R6 R7 R8 model ", tag}, gnt_mat, e);
    if (dir) check(tag, gnt_mat, dexp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_mat = '0;
    model_reset();
    #2;
    check("R11 grants zero in reset", gnt_mat, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r, e;
    model_reset();
    repeat (3) @(posedge clk);
    do_reset();

    // R6: every VC wants output 0; output rotates over inputs.
    r = '0;
    for (int i = 0; i < NI; i++) for (int v = 0; v < NV; v++) r[bidx(i, v, 0)] = 1'b1;
    apply(r, "R6 first grant in0 vc0", 1'b1, W'(1) << bidx(0, 0, 0));
    apply(r, "R6 next grant in1 vc0", 1'b1, W'(1) << bidx(1, 0, 0));
    apply(r, "R6 next grant in2 vc0", 1'b1, W'(1) << bidx(2, 0, 0));
    apply(r, "R6 next grant in3 vc0", 1'b1, W'(1) << bidx(3, 0, 0));
    apply(r, "R6 next grant in4 vc0", 1'b1, W'(1) << bidx(4, 0, 0));
    apply(r, "R5 wrap to in0 vc1", 1'b1, W'(1) << bidx(0, 1, 0));

    // R7: losing input keeps its VC pointer.
    do_reset();
    r = '0;
    r[bidx(0, 0, 0)] = 1'b1;
    r[bidx(1, 0, 0)] = 1'b1;
    r[bidx(1, 1, 1)] = 1'b1;
    apply(r, "R7 cycle1 in0 wins out0", 1'b1, W'(1) << bidx(0, 0, 0));
    apply(r, "R7 cycle2 in1 keeps vc0", 1'b1, W'(1) << bidx(1, 0, 0));
    apply(r, "R7 cycle3 in1 vc1 and in0", 1'b1,
          (W'(1) << bidx(1, 1, 1)) | (W'(1) << bidx(0, 0, 0)));

    // R4: only the lowest set output of a VC is its target.
    do_reset();
    r = '0;
    r[bidx(2, 1, 3)] = 1'b1;
    r[bidx(2, 1, 1)] = 1'b1;
    apply(r, "R4 lowest output chosen", 1'b1, W'(1) << bidx(2, 1, 1));

    // R8: idle output keeps its pointer while another output moves.
    do_reset();
    r = '0; r[bidx(0, 0, 0)] = 1'b1;
    apply(r, "R8 out0 grants in0", 1'b1, W'(1) << bidx(0, 0, 0));
    r = '0; r[bidx(0, 0, 1)] = 1'b1; r[bidx(1, 0, 1)] = 1'b1;
    apply(r, "R8 idle out1 still favours in0", 1'b1, W'(1) << bidx(0, 0, 1));

    // R9: mid-cycle change of requests alters grants without an edge.
    @(negedge clk);
    r = '0; r[bidx(3, 0, 2)] = 1'b1;
    req_mat = r;
    #1;
    model(r, 1'b0, e);
    check("R9 first request pattern", gnt_mat, e);
    r = '0; r[bidx(4, 1, 4)] = 1'b1;
    req_mat = r;
    #1;
    model(r, 1'b1, e);
    check("R9 changed pattern same cycle", gnt_mat, W'(1) << bidx(4, 1, 4));

    // R10 and R1..R3 under random traffic, model compared every cycle.
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] rr;
      for (int b = 0; b < W; b++) rr[b] = ($urandom % 4) == 0;
      if (n % 50 == 0) rr = '0;
      apply(rr, "R1 R2 R3 R10 random", 1'b0, '0);
      n_chk++;
      if ((rr != '0) && (gnt_mat == '0)) begin
        n_fail++;
        $display("FAIL R10: got %h expected nonzero", gnt_mat);
      end
    end

    // Heavy load: all bits set.
    for (int n = 0; n < 20; n++) apply('1, "R5 R6 full load", 1'b0, '0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule